// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between a UART receive deserializer and the register interface. Each character that the deserializer finishes is pushed together with three per-character error marks: parity error, framing error and break. Bus reads of the data register pop the oldest character. Bus reads of the line status register clear the sticky status bits. The data byte and the three marks of the oldest stored character are always visible at the outputs, so a status read reports the errors of the next character that a data read will return.

The block also produces the level signals that the interrupt logic and the modem pins use. These are a data-ready flag, a received-data-available signal compared against a selectable trigger level, a sticky overrun flag, a sticky flag for errors still held in the queue, and a request-to-send output for automatic flow control. When queueing is disabled the block works as a single holding register.

Top module: `rx_fifo_lsr`

## Requirements
- R1: After reset, data_ready_o, rx_avail_o, overrun_o, any_err_o and rts_o are 0, and rd_data_o and the three head flags are 0.
- R2: Characters leave in arrival order. rd_data_o shows the oldest stored byte, and a cycle with rd_data_i high removes that byte. When the queue is empty, rd_data_o is 0 and rd_data_i has no effect.
- R3: head_pe_o, head_fe_o and head_brk_o are the parity, framing and break marks that were stored with the character currently on rd_data_o.
- R4: A push while the queue is full and no pop occurs in the same cycle drops the character and sets overrun_o on the next cycle. A cycle with rd_lsr_i high clears overrun_o unless a drop happens in that same cycle.
- R5: Accepting a character with any mark set makes any_err_o 1. A cycle with rd_lsr_i high clears any_err_o only if no marked character is left after that cycle. Popping marked characters without a status read leaves any_err_o set.
- R6: data_ready_o is 1 exactly when at least one character is stored.
- R7: rx_avail_o is 1 when the stored count is at or above the trigger level selected by trig_sel_i: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14.
- R8: flush_i empties the queue and clears any_err_o on the next cycle. A push or pop in the same cycle is ignored, and overrun_o is kept.
- R9: With rts_force_i and afc_en_i high, rts_o goes to 1 one cycle after a cycle in which the count is below the trigger level. It goes to 0 one cycle after start_bit_i is seen while the count is at or above that level. Otherwise it holds its value.
- R10: With rts_force_i low, rts_o is 0 on the next cycle whatever afc_en_i is. With rts_force_i high and afc_en_i low, rts_o is 1 on the next cycle.
- R11: With fifo_en_i low, the capacity is one character and the trigger level is 1, whatever trig_sel_i selects.
- R12: A push and a pop in the same cycle on a full queue both take effect. The count stays full and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects full-depth queueing, 0 selects a single holding register |
| flush_i | input | 1 | Single-cycle request to empty the queue |
| trig_sel_i | input | 2 | Trigger level code |
| wr_valid_i | input | 1 | Push strobe from the deserializer |
| wr_data_i | input | 8 | Received byte |
| wr_pe_i | input | 1 | Parity error mark for the received byte |
| wr_fe_i | input | 1 | Framing error mark for the received byte |
| wr_brk_i | input | 1 | Break mark for the received byte |
| rd_data_i | input | 1 | Data register read (pop) |
| rd_lsr_i | input | 1 | Line status register read |
| rts_force_i | input | 1 | Software request-to-send enable |
| afc_en_i | input | 1 | Automatic flow control enable |
| start_bit_i | input | 1 | Start bit seen by the deserializer |
| rd_data_o | output | 8 | Oldest stored byte, 0 when empty |
| head_pe_o | output | 1 | Parity mark of the oldest byte |
| head_fe_o | output | 1 | Framing mark of the oldest byte |
| head_brk_o | output | 1 | Break mark of the oldest byte |
| data_ready_o | output | 1 | At least one byte is stored |
| rx_avail_o | output | 1 | Count at or above the trigger level |
| overrun_o | output | 1 | Sticky: a byte was dropped |
| any_err_o | output | 1 | Sticky: marked bytes were stored |
| rts_o | output | 1 | Request to send, active high |

## Verification
A pointer that slips shows up at once on rd_data_o as a byte out of order. A count that drifts from the true fill shows on data_ready_o and rx_avail_o within a cycle, and on overrun_o at the next push near full. An error counter that gets out of step with the stored marks shows only later: any_err_o either fails to clear or clears too early at the next status read after the marked bytes drain. The bench therefore checks every output in every cycle against a queue model, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  // trigger code -> byte threshold
  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  rx_entry_t        wdata_i,
  output rx_entry_t        head_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = (cnt_q != '0) ? slot_q[rd_ptr_q] : '0;
  assign count_o = cnt_q;

endmodule

// File: rtl/rx_err_track.sv
module rx_err_track #(
  parameter int unsigned CNT_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic push_i,
  input  logic push_err_i,
  input  logic pop_i,
  input  logic pop_err_i,
  input  logic drop_i,
  input  logic lsr_rd_i,
  output logic overrun_o,
  output logic any_err_o
);

  logic [CNT_W-1:0] err_cnt_q, err_cnt_d;
  logic             any_err_q, ovr_q;
  logic             inc, dec;

  assign inc = push_i && push_err_i;
  assign dec = pop_i && pop_err_i;

  always_comb begin
    err_cnt_d = err_cnt_q;
    if (flush_i)         err_cnt_d = '0;
    else if (inc && !dec) err_cnt_d = err_cnt_q + 1'b1;
    else if (dec && !inc) err_cnt_d = err_cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_q <= '0;
      any_err_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      err_cnt_q <= err_cnt_d;
      if (flush_i)                              any_err_q <= 1'b0;
      else if (inc)                             any_err_q <= 1'b1;
      else if (lsr_rd_i && err_cnt_d == '0)     any_err_q <= 1'b0;
      // set wins over read-clear
      if (drop_i)        ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;
    end
  end

  assign overrun_o = ovr_q;
  assign any_err_o = any_err_q;

endmodule

// File: rtl/rx_rts_ctrl.sv
module rx_rts_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic afc_i,
  input  logic start_i,
  input  logic at_trig_i,
  output logic rts_o
);

  logic rts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rts_q <= 1'b0;
    else if (!force_i)          rts_q <= 1'b0;
    else if (!afc_i)            rts_q <= 1'b1;
    else if (!at_trig_i)        rts_q <= 1'b1;
    else if (start_i)           rts_q <= 1'b0;
  end

  assign rts_o = rts_q;

endmodule

// File: rtl/rx_fifo_lsr.sv
module rx_fifo_lsr
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       flush_i,
  input  logic [1:0] trig_sel_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_pe_i,
  input  logic       wr_fe_i,
  input  logic       wr_brk_i,
  input  logic       rd_data_i,
  input  logic       rd_lsr_i,
  input  logic       rts_force_i,
  input  logic       afc_en_i,
  input  logic       start_bit_i,
  output logic [7:0] rd_data_o,
  output logic       head_pe_o,
  output logic       head_fe_o,
  output logic       head_brk_o,
  output logic       data_ready_o,
  output logic       rx_avail_o,
  output logic       overrun_o,
  output logic       any_err_o,
  output logic       rts_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_entry_t        wr_entry, head;
  logic [CNT_W-1:0] fill_cnt, cap, thr;
  logic             full, pop_ok, push_ok, drop, at_trig;

  assign wr_entry = '{brk: wr_brk_i, fe: wr_fe_i, pe: wr_pe_i, data: wr_data_i};

  assign cap     = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign thr     = fifo_en_i ? CNT_W'(trig_bytes(trig_sel_i)) : CNT_W'(1);
  assign full    = fill_cnt >= cap;
  assign pop_ok  = rd_data_i && !flush_i && (fill_cnt != '0);
  assign push_ok = wr_valid_i && !flush_i && (!full || pop_ok);
  assign drop    = wr_valid_i && !flush_i && full && !pop_ok;
  assign at_trig = fill_cnt >= thr;

  rx_fifo_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (push_ok),
    .pop_i   (pop_ok),
    .wdata_i (wr_entry),
    .head_o  (head),
    .count_o (fill_cnt)
  );

  rx_err_track #(.CNT_W(CNT_W)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .push_i     (push_ok),
    .push_err_i (wr_pe_i | wr_fe_i | wr_brk_i),
    .pop_i      (pop_ok),
    .pop_err_i  (head.pe | head.fe | head.brk),
    .drop_i     (drop),
    .lsr_rd_i   (rd_lsr_i),
    .overrun_o  (overrun_o),
    .any_err_o  (any_err_o)
  );

  rx_rts_ctrl u_rts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .force_i   (rts_force_i),
    .afc_i     (afc_en_i),
    .start_i   (start_bit_i),
    .at_trig_i (at_trig),
    .rts_o     (rts_o)
  );

  assign rd_data_o    = head.data;
  assign head_pe_o    = head.pe;
  assign head_fe_o    = head.fe;
  assign head_brk_o   = head.brk;
  assign data_ready_o = fill_cnt != '0;
  assign rx_avail_o   = at_trig;

endmodule

// File: rtl/rx_fifo_lsr_chk.sv
module rx_fifo_lsr_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             flush_i,
  input logic             wr_valid_i,
  input logic             wr_pe_i,
  input logic             wr_fe_i,
  input logic             wr_brk_i,
  input logic             rd_data_i,
  input logic             rts_force_i,
  input logic [CNT_W-1:0] fill_i,
  input logic [7:0]       rd_data_o,
  input logic             data_ready_o,
  input logic             overrun_o,
  input logic             any_err_o,
  input logic             rts_o
);

  logic [CNT_W-1:0] cap_w;
  assign cap_w = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);

  assert_empty_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == '0) |-> (rd_data_o == 8'd0 && !data_ready_o));

  assert_pop_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !wr_valid_i && !flush_i && fill_i != '0) |=> (fill_i == $past(fill_i) - CNT_W'(1)));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !rd_data_i && !flush_i && fill_i >= cap_w) |=> (overrun_o && fill_i == $past(fill_i)));

  assert_err_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !flush_i && fill_i < cap_w && (wr_pe_i || wr_fe_i || wr_brk_i)) |=> any_err_o);

  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (fill_i == '0 && !any_err_o && !data_ready_o));

  assert_rts_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_force_i |=> !rts_o);

endmodule

bind rx_fifo_lsr rx_fifo_lsr_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_en_i    (fifo_en_i),
  .flush_i      (flush_i),
  .wr_valid_i   (wr_valid_i),
  .wr_pe_i      (wr_pe_i),
  .wr_fe_i      (wr_fe_i),
  .wr_brk_i     (wr_brk_i),
  .rd_data_i    (rd_data_i),
  .rts_force_i  (rts_force_i),
  .fill_i       (fill_cnt),
  .rd_data_o    (rd_data_o),
  .data_ready_o (data_ready_o),
  .overrun_o    (overrun_o),
  .any_err_o    (any_err_o),
  .rts_o        (rts_o)
);

// File: tb/rx_fifo_lsr_tb.sv
module rx_fifo_lsr_tb_top;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en = 1'b1, flush = 1'b0;
  logic [1:0] trig = 2'd0;
  logic       wv = 1'b0, pe = 1'b0, fe = 1'b0, brk = 1'b0;
  logic [7:0] wd = 8'd0;
  logic       rd = 1'b0, lsr = 1'b0, force_rts = 1'b0, afc = 1'b0, start = 1'b0;
  logic [7:0] rd_data;
  logic       h_pe, h_fe, h_brk, dready, ravail, ovr, anyerr, rts;

  always #(CLK_P/2) clk = ~clk;

  rx_fifo_lsr #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .flush_i(flush),
    .trig_sel_i(trig), .wr_valid_i(wv), .wr_data_i(wd), .wr_pe_i(pe),
    .wr_fe_i(fe), .wr_brk_i(brk), .rd_data_i(rd), .rd_lsr_i(lsr),
    .rts_force_i(force_rts), .afc_en_i(afc), .start_bit_i(start),
    .rd_data_o(rd_data), .head_pe_o(h_pe), .head_fe_o(h_fe), .head_brk_o(h_brk),
    .data_ready_o(dready), .rx_avail_o(ravail), .overrun_o(ovr),
    .any_err_o(anyerr), .rts_o(rts)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model: entry = {brk, fe, pe, data}; index 0 is oldest
  logic [10:0] mq [DEPTH];
  int   mcnt = 0, merr = 0;
  logic movr = 1'b0, many = 1'b0, mrts = 1'b0;

  function automatic int thr_of(input logic en, input logic [1:0] s);
    if (!en) return 1;
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [10:0] head_of();
    return (mcnt > 0) ? mq[0] : 11'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [10:0] h;
    h = head_of();
    chk("R2 rd_data", 32'(rd_data), 32'(h[7:0]));
    chk("R3 head flags", 32'({h_brk, h_fe, h_pe}), 32'(h[10:8]));
    chk("R4 overrun", 32'(ovr), 32'(movr));
    chk("R5 any_err", 32'(anyerr), 32'(many));
    chk("R6 data_ready", 32'(dready), 32'(mcnt > 0));
    chk("R7 rx_avail", 32'(ravail), 32'(mcnt >= thr_of(fifo_en, trig)));
    chk("R9 rts", 32'(rts), 32'(mrts));
  endtask

  // drive one cycle at negedge, update model at posedge, land on next negedge
  task automatic step(input logic i_wv, input logic [7:0] i_wd, input logic [2:0] i_err,
                      input logic i_rd, input logic i_lsr, input logic i_fl, input logic i_st);
    int cap, thr;
    logic popok, pushok, drop, push_e, pop_e;
    logic [10:0] h;
    wv = i_wv; wd = i_wd; {brk, fe, pe} = i_err;
    rd = i_rd; lsr = i_lsr; flush = i_fl; start = i_st;
    cap = fifo_en ? DEPTH : 1;
    thr = thr_of(fifo_en, trig);
    h = head_of();
    popok  = i_rd && !i_fl && mcnt > 0;
    pushok = i_wv && !i_fl && (mcnt < cap || popok);
    drop   = i_wv && !i_fl && mcnt >= cap && !popok;
    push_e = pushok && (i_err != 3'd0);
    pop_e  = popok && (h[10:8] != 3'd0);
    @(posedge clk);
    if (!force_rts) mrts = 1'b0;
    else if (!afc) mrts = 1'b1;
    else if (mcnt < thr) mrts = 1'b1;
    else if (i_st) mrts = 1'b0;
    if (i_fl) begin
      mcnt = 0; merr = 0; many = 1'b0;
    end else begin
      if (popok) begin
        for (int k = 0; k < DEPTH - 1; k++) mq[k] = mq[k+1];
        mcnt--;
      end
      if (pushok) begin
        mq[mcnt] = {i_err, i_wd};
        mcnt++;
      end
      merr = merr + (push_e ? 1 : 0) - (pop_e ? 1 : 0);
      if (push_e) many = 1'b1;
      else if (i_lsr && merr == 0) many = 1'b0;
    end
    if (drop) movr = 1'b1;
    else if (i_lsr) movr = 1'b0;
    @(negedge clk);
    wv = 1'b0; rd = 1'b0; lsr = 1'b0; flush = 1'b0; start = 1'b0;
    check_all();
  endtask

  task automatic idle(); step(1'b0, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic push(input logic [7:0] d, input logic [2:0] e); step(1'b1, d, e, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic pop(); step(1'b0, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0); endtask
  task automatic rdlsr(); step(1'b0, 8'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0); endtask
  task automatic do_flush(); step(1'b0, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held and after release
    chk("R1 reset outs", 32'({dready, ravail, ovr, anyerr, rts}), 32'd0);
    chk("R1 reset head", 32'({h_brk, h_fe, h_pe, rd_data}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all();

    // R2 empty pop has no effect
    pop();
    chk("R2 empty pop", 32'(dready), 32'd0);

    // fill, check thresholds (R7) and ordering
    for (int i = 0; i < DEPTH; i++) begin
      push(8'(8'h30 + i), 3'd0);
      for (int t = 0; t < 4; t++) begin
        trig = 2'(t);
        #1;
        chk("R7 threshold", 32'(ravail), 32'((i + 1) >= thr_of(1'b1, 2'(t))));
      end
    end
    trig = 2'd0;
    // R4 overflow drops the byte
    push(8'hEE, 3'd0);
    chk("R4 overrun set", 32'(ovr), 32'd1);
    // R12 push+pop on full
    step(1'b1, 8'hA5, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R12 full push+pop", 32'(ovr), 32'd1);
    chk("R12 head moved", 32'(rd_data), 32'h31);
    rdlsr();
    chk("R4 lsr clears", 32'(ovr), 32'd0);
    for (int i = 0; i < DEPTH; i++) pop();
    chk("R2 drained", 32'(dready), 32'd0);

    // R3/R5 per-entry marks
    push(8'h11, 3'b001);
    push(8'h22, 3'b000);
    push(8'h33, 3'b100);
    chk("R3 head pe", 32'({h_brk, h_fe, h_pe}), 32'b001);
    rdlsr();
    chk("R5 lsr keeps", 32'(anyerr), 32'd1);
    pop(); pop();
    chk("R3 head brk", 32'({h_brk, h_fe, h_pe}), 32'b100);
    pop();
    chk("R5 sticky after drain", 32'(anyerr), 32'd1);
    rdlsr();
    chk("R5 lsr clears", 32'(anyerr), 32'd0);

    // R8 flush
    push(8'h44, 3'b010);
    push(8'h55, 3'd0);
    push(8'hEE, 3'd0); // no overrun, just to keep ovr state known
    step(1'b1, 8'h66, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8 flush empty", 32'({dready, anyerr}), 32'd0);

    // R9 auto RTS with trigger 4
    trig = 2'd1; force_rts = 1'b1; afc = 1'b1;
    idle(); idle();
    chk("R9 rts below trig", 32'(rts), 32'd1);
    for (int i = 0; i < 4; i++) push(8'(i), 3'd0);
    idle();
    chk("R9 rts holds at trig", 32'(rts), 32'd1);
    step(1'b0, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 rts start drop", 32'(rts), 32'd0);
    pop(); idle();
    chk("R9 rts reassert", 32'(rts), 32'd1);
    // R10
    force_rts = 1'b0; idle();
    chk("R10 force clear", 32'(rts), 32'd0);
    force_rts = 1'b1; afc = 1'b0; idle();
    chk("R10 force only", 32'(rts), 32'd1);
    do_flush();

    // R11 single holding register
    fifo_en = 1'b0; trig = 2'd3;
    push(8'h77, 3'd0);
    chk("R11 trig is one", 32'(ravail), 32'd1);
    push(8'h78, 3'd0);
    chk("R11 cap one", 32'({ovr, rd_data}), 32'h177);
    rdlsr(); pop();
    fifo_en = 1'b1; do_flush();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] e;
      if (n % 250 == 0) begin
        trig = 2'($urandom_range(0, 3));
        force_rts = 1'($urandom_range(0, 3) != 0);
        afc = 1'($urandom_range(0, 3) != 0);
      end
      e = 3'd0;
      if ($urandom_range(0, 9) == 0) e[0] = 1'b1;
      if ($urandom_range(0, 9) == 0) e[1] = 1'b1;
      if ($urandom_range(0, 19) == 0) e[2] = 1'b1;
      step(1'($urandom_range(0, 99) < 55), 8'($urandom), e,
           1'($urandom_range(0, 99) < 45), 1'($urandom_range(0, 99) < 15),
           1'($urandom_range(0, 199) == 0), 1'($urandom_range(0, 99) < 20));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule